// File: doc/BRIEF.md
# Network Memory-Control Packet Decoder

This block sits behind the network receive path and turns the payload of a control datagram into commands for a memory and processor controller. The payload arrives as 32-bit words with a start marker on the first word and an end marker on the last. The first word holds an opcode. The decoder either writes a byte string into memory as a run of word writes, issues a single word read, or tells the processor to start or to halt. Opcodes it does not recognise are dropped without any effect.

A write payload has a header of three words after the opcode: a byte count, a sequence number and a starting address. The data bytes follow, packed four to a word. Each data word becomes one write command, and the address steps by the word size. When the byte count is not a multiple of four, the last write carries a byte-enable mask that covers only the bytes that are present. If a packet ends before its declared content has arrived, the decoder raises a one-cycle error and drops the rest. A write packet that completes latches its sequence number so that reply logic can acknowledge it.

There is no backpressure in either direction. Every command is a single-cycle pulse, registered one cycle after the input word that produced it.

Top module: `ctrl_pkt_decoder`

## Requirements
- R1: After reset, `cmd_valid` and `err_trunc` are 0 and `seq_out` is 0.
- R2: The opcode is bits [7:0] of the word that carries `in_sop`, and the upper bits are ignored. 0x64 means write, 0x60 read, 0x50 start and 0x54 halt. `cmd_op` encodes write as 0, read as 1, start as 2 and halt as 3. A command is visible exactly one clock after the input word that triggers it and lasts one cycle.
- R3: A start or halt opcode issues one command on its own opcode word, with `cmd_addr`, `cmd_data` and `cmd_be` all 0.
- R4: For a read, the word after the opcode is the address. It issues one read command with that address, with `cmd_data` 0 and `cmd_be` 0.
- R5: For a write, the three words after the opcode are the byte count (low LEN_W bits), the sequence number and the start address. Each following data word issues one write command. `cmd_data` is the data word unchanged, and bits [7:0] hold the first byte of that word. The first write goes to the start address, and each later write goes 4 higher.
- R6: Bit i of `cmd_be` enables bits [8i+7:8i]. Full data words have `cmd_be` = 4'b1111. The final word of a byte count that is not a multiple of 4 has only its low (count mod 4) bits set.
- R7: Data words that arrive after the byte count is used up issue no command.
- R8: If the end marker arrives before the header, the read address or the declared data is complete, `err_trunc` pulses for one cycle, one clock after that word. No further command is issued for that packet, and `seq_out` does not change.
- R9: When a write packet ends with all of its declared bytes received, `seq_out` takes that packet's sequence number one clock after the end word. A byte count of 0 counts as complete once the address word has arrived.
- R10: A packet with an unknown opcode issues no command and raises no error. Its remaining words are ignored.
- R11: Words that arrive without a start marker while no packet is open are ignored.
- R12: Cycles with `in_valid` low neither advance the parse nor issue commands, so gaps inside a packet do not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload word present this cycle |
| in_sop | input | 1 | Word is the first of a packet |
| in_eop | input | 1 | Word is the last of a packet |
| in_data | input | DATA_W | Payload word |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 2 | Command kind: 0 write, 1 read, 2 start, 3 halt |
| cmd_addr | output | ADDR_W | Byte address of the command |
| cmd_data | output | DATA_W | Write data |
| cmd_be | output | DATA_W/8 | Byte-lane enables for writes |
| err_trunc | output | 1 | One-cycle pulse on a truncated packet |
| seq_out | output | SEQ_W | Sequence number of the last completed write packet |

## Verification
The assertions assume that `in_valid` is low during reset. They also assume that an end marker, an error or a sequence update always follows a valid input word. The stimulus therefore holds `in_valid` low throughout reset and between packets, and it drives input words only on falling edges. Each scenario finishes its packet with an end marker before the next start marker. This keeps the parse state clean for the next scenario, because a start marker that arrives in the middle of a packet restarts decoding.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_START = 2'd2,
        OP_HALT  = 2'd3
    } cmd_op_e;

    localparam logic [7:0] CODE_WRITE = 8'h64;
    localparam logic [7:0] CODE_READ  = 8'h60;
    localparam logic [7:0] CODE_START = 8'h50;
    localparam logic [7:0] CODE_HALT  = 8'h54;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEN,
        ST_SEQ,
        ST_ADDR,
        ST_DATA,
        ST_RDADDR,
        ST_DRAIN
    } parse_st_e;

    // per-word control decisions from the parser
    typedef struct packed {
        logic    issue;
        cmd_op_e op;
        logic    load_len;
        logic    load_seq;
        logic    load_addr;
        logic    step;
        logic    commit;
        logic    err;
    } ctl_s;

endpackage

// File: rtl/cpd_parse_fsm.sv
module cpd_parse_fsm
    import cpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic       in_eop,
    input  logic [7:0] opcode,
    input  logic       rem_zero,
    input  logic       rem_fits,
    output ctl_s       ctl
);

    parse_st_e st, nxt;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    always_comb begin
        ctl = '0;
        nxt = st;
        if (in_valid) begin
            if (in_sop) begin
                nxt = in_eop ? ST_IDLE : ST_DRAIN;
                case (opcode)
                    CODE_WRITE: begin
                        if (in_eop) ctl.err = 1'b1;
                        else        nxt = ST_LEN;
                    end
                    CODE_READ: begin
                        if (in_eop) ctl.err = 1'b1;
                        else        nxt = ST_RDADDR;
                    end
                    CODE_START: begin
                        ctl.issue = 1'b1;
                        ctl.op    = OP_START;
                    end
                    CODE_HALT: begin
                        ctl.issue = 1'b1;
                        ctl.op    = OP_HALT;
                    end
                    default: ;
                endcase
            end else begin
                case (st)
                    ST_LEN: begin
                        ctl.load_len = 1'b1;
                        if (in_eop) begin
                            ctl.err = 1'b1;
                            nxt     = ST_IDLE;
                        end else begin
                            nxt = ST_SEQ;
                        end
                    end
                    ST_SEQ: begin
                        ctl.load_seq = 1'b1;
                        if (in_eop) begin
                            ctl.err = 1'b1;
                            nxt     = ST_IDLE;
                        end else begin
                            nxt = ST_ADDR;
                        end
                    end
                    ST_ADDR: begin
                        ctl.load_addr = 1'b1;
                        if (in_eop) begin
                            nxt = ST_IDLE;
                            if (rem_zero) ctl.commit = 1'b1;
                            else          ctl.err    = 1'b1;
                        end else begin
                            nxt = ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (!rem_zero) begin
                            ctl.issue = 1'b1;
                            ctl.op    = OP_WRITE;
                            ctl.step  = 1'b1;
                        end
                        if (in_eop) begin
                            nxt = ST_IDLE;
                            if (rem_fits) ctl.commit = 1'b1;
                            else          ctl.err    = 1'b1;
                        end
                    end
                    ST_RDADDR: begin
                        ctl.issue = 1'b1;
                        ctl.op    = OP_READ;
                        nxt       = in_eop ? ST_IDLE : ST_DRAIN;
                    end
                    ST_DRAIN: begin
                        if (in_eop) nxt = ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cpd_wr_cursor.sv
module cpd_wr_cursor #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_len,
    input  logic              load_addr,
    input  logic              step,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LANES-1:0]  cur_be,
    output logic              rem_zero,
    output logic              rem_fits
);

    localparam logic [LEN_W-1:0]  LANES_LEN = LEN_W'(LANES);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(LANES);

    logic [LEN_W-1:0] rem;

    assign rem_zero = (rem == '0);
    assign rem_fits = (rem <= LANES_LEN);

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            cur_be[i] = (rem > LEN_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem      <= '0;
            cur_addr <= '0;
        end else begin
            if (load_len) rem <= len_in;
            else if (step) rem <= rem_fits ? '0 : rem - LANES_LEN;

            if (load_addr) cur_addr <= addr_in;
            else if (step) cur_addr <= cur_addr + ADDR_STEP;
        end
    end

endmodule

// File: rtl/ctrl_pkt_decoder.sv
module ctrl_pkt_decoder
    import cpd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int SEQ_W  = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_sop,
    input  logic                in_eop,
    input  logic [DATA_W-1:0]   in_data,
    output logic                cmd_valid,
    output logic [1:0]          cmd_op,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [DATA_W-1:0]   cmd_data,
    output logic [DATA_W/8-1:0] cmd_be,
    output logic                err_trunc,
    output logic [SEQ_W-1:0]    seq_out
);

    localparam int LANES = DATA_W / 8;

    ctl_s              ctl;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  cur_be;
    logic              rem_zero;
    logic              rem_fits;
    logic [SEQ_W-1:0]  seq_pend;
    cmd_op_e           op_q;

    cpd_parse_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .opcode   (in_data[7:0]),
        .rem_zero (rem_zero),
        .rem_fits (rem_fits),
        .ctl      (ctl)
    );

    cpd_wr_cursor #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .LANES  (LANES)
    ) u_cursor (
        .clk       (clk),
        .rst       (rst),
        .load_len  (ctl.load_len),
        .load_addr (ctl.load_addr),
        .step      (ctl.step),
        .len_in    (in_data[LEN_W-1:0]),
        .addr_in   (in_data[ADDR_W-1:0]),
        .cur_addr  (cur_addr),
        .cur_be    (cur_be),
        .rem_zero  (rem_zero),
        .rem_fits  (rem_fits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            op_q      <= OP_WRITE;
            cmd_addr  <= '0;
            cmd_data  <= '0;
            cmd_be    <= '0;
            err_trunc <= 1'b0;
            seq_pend  <= '0;
            seq_out   <= '0;
        end else begin
            cmd_valid <= ctl.issue;
            err_trunc <= ctl.err;
            if (ctl.load_seq) seq_pend <= in_data[SEQ_W-1:0];
            if (ctl.commit)   seq_out  <= seq_pend;
            if (ctl.issue) begin
                op_q <= ctl.op;
                case (ctl.op)
                    OP_WRITE: begin
                        cmd_addr <= cur_addr;
                        cmd_data <= in_data;
                        cmd_be   <= cur_be;
                    end
                    OP_READ: begin
                        cmd_addr <= in_data[ADDR_W-1:0];
                        cmd_data <= '0;
                        cmd_be   <= '0;
                    end
                    default: begin
                        cmd_addr <= '0;
                        cmd_data <= '0;
                        cmd_be   <= '0;
                    end
                endcase
            end
        end
    end

    assign cmd_op = op_q;

endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int SEQ_W  = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_eop,
    input logic                cmd_valid,
    input logic [1:0]          cmd_op,
    input logic [ADDR_W-1:0]   cmd_addr,
    input logic [DATA_W-1:0]   cmd_data,
    input logic [DATA_W/8-1:0] cmd_be,
    input logic                err_trunc,
    input logic [SEQ_W-1:0]    seq_out
);

    localparam int LANES = DATA_W / 8;

    assert_cmd_after_word_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(in_valid));

    assert_ctl_cmd_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op[1]) |-> (cmd_addr == '0 && cmd_data == '0 && cmd_be == '0));

    assert_read_no_data_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1) |-> (cmd_data == '0 && cmd_be == '0));

    assert_be_low_contig_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd0) |->
            (cmd_be != '0 && ((cmd_be + LANES'(1)) & cmd_be) == '0));

    assert_err_after_eop_R8: assert property (@(posedge clk) disable iff (rst)
        err_trunc |-> $past(in_valid && in_eop));

    assert_seq_after_eop_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(seq_out) |-> $past(in_valid && in_eop));

endmodule

bind ctrl_pkt_decoder cpd_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .SEQ_W  (SEQ_W)
) i_cpd_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_eop    (in_eop),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_be    (cmd_be),
    .err_trunc (err_trunc),
    .seq_out   (seq_out)
);

// File: tb/test_ctrl_pkt_decoder.sv
`timescale 1ns/1ps
module test_ctrl_pkt_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [31:0] in_data = '0;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [31:0] cmd_addr;
    logic [31:0] cmd_data;
    logic [3:0]  cmd_be;
    logic        err_trunc;
    logic [31:0] seq_out;

    int n_total = 0;
    int n_fail  = 0;
    int n_cmd   = 0;
    int n_err   = 0;
    logic [1:0]  lg_op   [0:15];
    logic [31:0] lg_addr [0:15];
    logic [31:0] lg_data [0:15];
    logic [3:0]  lg_be   [0:15];

    always #10 clk = ~clk;

    ctrl_pkt_decoder i_ctrl_pkt_decoder (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .cmd_be    (cmd_be),
        .err_trunc (err_trunc),
        .seq_out   (seq_out)
    );

    // output log, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst && cmd_valid && n_cmd < 16) begin
            lg_op[n_cmd]   = cmd_op;
            lg_addr[n_cmd] = cmd_addr;
            lg_data[n_cmd] = cmd_data;
            lg_be[n_cmd]   = cmd_be;
            n_cmd = n_cmd + 1;
        end
        if (!rst && err_trunc) n_err = n_err + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(posedge clk);
        n_cmd = 0;
        n_err = 0;
    endtask

    task automatic word(input logic [31:0] d, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1;
        in_sop   = s;
        in_eop   = e;
        in_data  = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sop   = 1'b0;
            in_eop   = 1'b0;
            in_data  = '0;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 cmd_valid", {31'b0, cmd_valid}, 32'd0);
        check("R1 err_trunc", {31'b0, err_trunc}, 32'd0);
        check("R1 seq_out", seq_out, 32'd0);
        rst = 1'b0;
        idle(2);
    endtask

    task automatic t_write_full();
        clear_log();
        word(32'h0000_0064, 1, 0);
        word(32'd8, 0, 0);
        word(32'd7, 0, 0);
        word(32'h0000_0100, 0, 0);
        word(32'h4433_2211, 0, 0);
        word(32'h8877_6655, 0, 1);
        idle(3);
        check("R5 write count", n_cmd, 2);
        check("R5 op0", {30'b0, lg_op[0]}, 32'd0);
        check("R5 addr0", lg_addr[0], 32'h100);
        check("R5 data0", lg_data[0], 32'h4433_2211);
        check("R6 be0", {28'b0, lg_be[0]}, 32'hF);
        check("R5 addr1", lg_addr[1], 32'h104);
        check("R5 data1", lg_data[1], 32'h8877_6655);
        check("R6 be1", {28'b0, lg_be[1]}, 32'hF);
        check("R9 seq", seq_out, 32'd7);
        check("R8 no err", n_err, 0);
    endtask

    task automatic t_write_partial();
        clear_log();
        word(32'h0000_0064, 1, 0);
        word(32'd6, 0, 0);
        word(32'd9, 0, 0);
        word(32'h0000_2000, 0, 0);
        word(32'hDDCC_BBAA, 0, 0);
        word(32'h0000_FFEE, 0, 1);
        idle(3);
        check("R6 partial count", n_cmd, 2);
        check("R6 full be", {28'b0, lg_be[0]}, 32'hF);
        check("R6 tail be", {28'b0, lg_be[1]}, 32'h3);
        check("R5 tail addr", lg_addr[1], 32'h2004);
        check("R9 partial seq", seq_out, 32'd9);
    endtask

    task automatic t_write_extra();
        clear_log();
        word(32'h0000_0064, 1, 0);
        word(32'd4, 0, 0);
        word(32'h11, 0, 0);
        word(32'h0000_0040, 0, 0);
        word(32'hCAFE_0001, 0, 0);
        word(32'hCAFE_0002, 0, 1);
        idle(3);
        check("R7 extra words ignored", n_cmd, 1);
        check("R7 data kept", lg_data[0], 32'hCAFE_0001);
        check("R9 seq after extra", seq_out, 32'h11);
    endtask

    task automatic t_write_trunc();
        clear_log();
        word(32'h0000_0064, 1, 0);
        word(32'd8, 0, 0);
        word(32'h55, 0, 0);
        word(32'h0000_0080, 0, 0);
        word(32'h1234_5678, 0, 1);
        idle(1);
        check("R8 err pulse timing", {31'b0, err_trunc}, 32'd1);
        idle(3);
        check("R8 data trunc cmds", n_cmd, 1);
        check("R8 data trunc err", n_err, 1);
        check("R8 seq held", seq_out, 32'h11);
        clear_log();
        word(32'h0000_0064, 1, 0);
        word(32'd12, 0, 1);
        idle(3);
        check("R8 header trunc cmds", n_cmd, 0);
        check("R8 header trunc err", n_err, 1);
    endtask

    task automatic t_write_zero();
        clear_log();
        word(32'h0000_0064, 1, 0);
        word(32'd0, 0, 0);
        word(32'h22, 0, 0);
        word(32'h0000_0300, 0, 1);
        idle(3);
        check("R9 zero len cmds", n_cmd, 0);
        check("R9 zero len err", n_err, 0);
        check("R9 zero len seq", seq_out, 32'h22);
    endtask

    task automatic t_read();
        clear_log();
        word(32'h0000_0060, 1, 0);
        word(32'h4000_0000, 0, 1);
        idle(3);
        check("R4 read count", n_cmd, 1);
        check("R4 read op", {30'b0, lg_op[0]}, 32'd1);
        check("R4 read addr", lg_addr[0], 32'h4000_0000);
        check("R4 read be", {28'b0, lg_be[0]}, 32'd0);
        clear_log();
        word(32'h0000_0060, 1, 1);
        idle(3);
        check("R8 read trunc err", n_err, 1);
        check("R8 read trunc cmds", n_cmd, 0);
    endtask

    task automatic t_start_halt();
        clear_log();
        word(32'h1234_5650, 1, 1);
        idle(1);
        check("R2 one-cycle latency", {31'b0, cmd_valid}, 32'd1);
        idle(1);
        check("R2 single pulse", {31'b0, cmd_valid}, 32'd0);
        word(32'h0000_0054, 1, 1);
        idle(3);
        check("R3 count", n_cmd, 2);
        check("R3 start op", {30'b0, lg_op[0]}, 32'd2);
        check("R3 start addr", lg_addr[0], 32'd0);
        check("R3 halt op", {30'b0, lg_op[1]}, 32'd3);
        check("R3 halt data", lg_data[1], 32'd0);
    endtask

    task automatic t_unknown();
        clear_log();
        word(32'h0000_0077, 1, 0);
        word(32'd1, 0, 0);
        word(32'h0000_0050, 0, 0);
        word(32'd3, 0, 1);
        idle(3);
        check("R10 unknown cmds", n_cmd, 0);
        check("R10 unknown err", n_err, 0);
        check("R10 seq kept", seq_out, 32'h22);
    endtask

    task automatic t_stray();
        clear_log();
        word(32'h0000_0050, 0, 0);
        word(32'h0000_0064, 0, 1);
        idle(3);
        check("R11 stray cmds", n_cmd, 0);
        check("R11 stray err", n_err, 0);
    endtask

    task automatic t_gaps();
        clear_log();
        word(32'h0000_0064, 1, 0);
        idle(2);
        word(32'd3, 0, 0);
        idle(1);
        word(32'h33, 0, 0);
        idle(3);
        word(32'h0000_0500, 0, 0);
        idle(2);
        word(32'h00AB_CDEF, 0, 1);
        idle(3);
        check("R12 gap count", n_cmd, 1);
        check("R12 gap addr", lg_addr[0], 32'h500);
        check("R12 gap be", {28'b0, lg_be[0]}, 32'h7);
        check("R12 gap seq", seq_out, 32'h33);
    endtask

    initial begin
        #(20 * 100000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        t_reset();
        t_write_full();
        t_write_partial();
        t_write_extra();
        t_write_trunc();
        t_write_zero();
        t_read();
        t_start_halt();
        t_unknown();
        t_stray();
        t_gaps();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule